// File: doc/BRIEF.md
# Decimal Mailbox Processor

A small processor that works entirely in decimal. Its store holds one hundred cells, numbered 00 to 99 in two BCD digits, and every cell holds three BCD digits. A cell read as an instruction gives an opcode in its top digit and a two-digit cell number in the two lower digits. One accumulator of three BCD digits, with a separate negative flag, takes part in every arithmetic step. A two-digit BCD program counter selects the next instruction.

Each instruction takes one fetch cycle and one execute cycle. The only exception is an input request, which stays in its execute cycle until the input port offers a value. The processor writes values to the output as a registered word with a one-cycle strobe. A separate load port writes any cell at any time, including while reset is held. This is how a program and its data are placed in the store before the processor starts.

Top module: `mbx_cpu_top`

## Requirements
- R1: While reset is applied, `out_valid`, `in_ready` and `halted` are 0. The asynchronous reset is released through two clock stages. On the third rising edge after `rst_n` rises, the processor fetches cell 00 with accumulator 000 and the flag clear. Every instruction then takes a fetch cycle followed by an execute cycle.
- R2: A cell value is laid out as digit [11:8] = opcode, [7:4] = address tens and [3:0] = address ones. Opcode 1 sets the accumulator to (accumulator + cell) modulo 1000 and clears the flag.
- R3: Opcode 2 sets the accumulator digits to (accumulator − cell) modulo 1000, which is the ten's complement of the magnitude when the result is negative. It sets the flag exactly when the cell value is greater than the accumulator.
- R4: Opcode 5 copies the cell into the accumulator and clears the flag. Opcode 3 writes the accumulator digits into the cell.
- R5: Opcode 6 puts the address field into the program counter. Sequential stepping goes from 99 to 00.
- R6: Opcode 7 branches only when the accumulator digits are 000. Opcode 8 branches only while the flag is clear.
- R7: Code 901 holds the processor in its execute cycle with `in_ready` high until `in_valid` is seen high. The accumulator then takes `in_data` and the flag clears.
- R8: Code 902 drives `out_valid` high for exactly one cycle, the cycle after its execute cycle. With it, `out_data` carries the accumulator and `out_neg` carries the flag, and both hold until the next 902.
- R9: Code 000 stops the processor. `halted` then stays high until reset, and no further output strobe or input request appears.
- R10: Opcode 4, opcode 0 with a nonzero address, and opcode 9 with an address other than 01 or 02 change nothing but the program counter.
- R11: A load write and a store to the same cell in the same cycle leave the load value in the cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write strobe for the load port |
| ld_addr | input | 8 | Cell number for the load, two BCD digits |
| ld_data | input | 12 | Value for the load, three BCD digits |
| in_valid | input | 1 | Input port offers a value |
| in_data | input | 12 | Input value, three BCD digits |
| in_ready | output | 1 | Processor is waiting for an input value |
| out_valid | output | 1 | One-cycle strobe for a new output value |
| out_data | output | 12 | Output value, three BCD digits |
| out_neg | output | 1 | Negative flag sent with the output value |
| halted | output | 1 | Processor has stopped |

## Verification
The processor's own store and the load port can write the same cell on the same clock edge. The bench provokes this with a program that loads a constant and stores it to cell 51. Counting from the release of reset, it places one load of a different value to cell 51 exactly on the store's execute edge. The cell is then read back through a later load-and-output sequence, and the load value is expected to reach the output port. A behavioural decimal model in the bench follows the same edges. It applies the load after the store, and all outputs are compared against it on every cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int DIG_W = 4;

  localparam logic [3:0] OPC_HLT = 4'd0;
  localparam logic [3:0] OPC_ADD = 4'd1;
  localparam logic [3:0] OPC_SUB = 4'd2;
  localparam logic [3:0] OPC_STA = 4'd3;
  localparam logic [3:0] OPC_LDA = 4'd5;
  localparam logic [3:0] OPC_BRA = 4'd6;
  localparam logic [3:0] OPC_BRZ = 4'd7;
  localparam logic [3:0] OPC_BRP = 4'd8;
  localparam logic [3:0] OPC_IO  = 4'd9;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_HALT  = 2'd2
  } cpu_state_e;

endpackage

// File: rtl/mbx_mem.sv
module mbx_mem
  import mbx_pkg::*;
#(
  parameter int ADIG = 2,
  parameter int DDIG = 3
) (
  input  logic                  clk,
  input  logic                  ld_en,
  input  logic [ADIG*DIG_W-1:0] ld_addr,
  input  logic [DDIG*DIG_W-1:0] ld_data,
  input  logic                  st_en,
  input  logic [ADIG*DIG_W-1:0] st_addr,
  input  logic [DDIG*DIG_W-1:0] st_data,
  input  logic [ADIG*DIG_W-1:0] ra_addr,
  output logic [DDIG*DIG_W-1:0] ra_data,
  input  logic [ADIG*DIG_W-1:0] rb_addr,
  output logic [DDIG*DIG_W-1:0] rb_data
);

  localparam int AW    = ADIG * DIG_W;
  localparam int DW    = DDIG * DIG_W;
  localparam int NCELL = 10 ** ADIG;
  localparam int IW    = $clog2(NCELL);

  logic [DW-1:0] cells [NCELL];

  function automatic int cell_idx(input logic [AW-1:0] a);
    int v;
    v = 0;
    for (int d = ADIG - 1; d >= 0; d--) begin
      v = v * 10 + int'(a[d*DIG_W +: DIG_W]);
    end
    return v;
  endfunction

  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          wr_en;
  int            wr_i;
  int            ra_i;
  int            rb_i;

  // load port takes precedence over a processor store
  always_comb begin
    wr_en   = ld_en | st_en;
    wr_addr = ld_en ? ld_addr : st_addr;
    wr_data = ld_en ? ld_data : st_data;
    wr_i    = cell_idx(wr_addr);
    ra_i    = cell_idx(ra_addr);
    rb_i    = cell_idx(rb_addr);
    ra_data = (ra_i < NCELL) ? cells[ra_i[IW-1:0]] : '0;
    rb_data = (rb_i < NCELL) ? cells[rb_i[IW-1:0]] : '0;
  end

  always_ff @(posedge clk) begin
    if (wr_en && (wr_i < NCELL)) begin
      cells[wr_i[IW-1:0]] <= wr_data;
    end
  end

endmodule

// File: rtl/mbx_bcd_addsub.sv
module mbx_bcd_addsub
  import mbx_pkg::*;
#(
  parameter int NDIG = 3
) (
  input  logic [NDIG*DIG_W-1:0] a,
  input  logic [NDIG*DIG_W-1:0] b,
  input  logic                  sub,
  output logic [NDIG*DIG_W-1:0] sum,
  output logic                  borrow
);

  logic [NDIG:0] cy;

  assign cy[0] = sub;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    logic [DIG_W-1:0] bd;
    logic [DIG_W:0]   raw;
    // nine's complement of the subtrahend digit when subtracting
    assign bd  = sub ? (4'd9 - b[g*DIG_W +: DIG_W]) : b[g*DIG_W +: DIG_W];
    assign raw = {1'b0, a[g*DIG_W +: DIG_W]} + {1'b0, bd} + {4'b0000, cy[g]};
    assign cy[g+1] = (raw > 5'd9);
    assign sum[g*DIG_W +: DIG_W] = cy[g+1] ? 4'(raw - 5'd10) : raw[DIG_W-1:0];
  end

  assign borrow = sub & ~cy[NDIG];

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int DDIG = 3
) (
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic [DDIG*DIG_W-1:0]      instr,
  input  logic [DDIG*DIG_W-1:0]      opnd,
  output logic [(DDIG-1)*DIG_W-1:0]  pc_o,
  output logic [(DDIG-1)*DIG_W-1:0]  opaddr_o,
  output logic                       st_en,
  output logic [DDIG*DIG_W-1:0]      st_data,
  input  logic                       in_valid,
  input  logic [DDIG*DIG_W-1:0]      in_data,
  output logic                       in_ready,
  output logic                       out_valid,
  output logic [DDIG*DIG_W-1:0]      out_data,
  output logic                       out_neg,
  output logic                       halted
);

  localparam int ADIG = DDIG - 1;
  localparam int AW   = ADIG * DIG_W;
  localparam int DW   = DDIG * DIG_W;

  cpu_state_e    state_q, state_d;
  logic [AW-1:0] pc_q, pc_d;
  logic          pc_en;
  logic [DW-1:0] ir_q;
  logic          ir_en;
  logic [DW-1:0] acc_q, acc_d;
  logic          neg_q, neg_d;
  logic          acc_en;
  logic          outv_q, outv_d;
  logic [DW-1:0] outd_q;
  logic          outn_q;
  logic          out_en;

  logic [3:0]    op;
  logic [AW-1:0] adr;
  logic          alu_sub;
  logic [DW-1:0] alu_sum;
  logic          alu_borrow;

  function automatic logic [AW-1:0] bcd_inc(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    logic          c;
    r = v;
    c = 1'b1;
    for (int d = 0; d < ADIG; d++) begin
      if (c) begin
        if (r[d*DIG_W +: DIG_W] == 4'd9) begin
          r[d*DIG_W +: DIG_W] = 4'd0;
        end else begin
          r[d*DIG_W +: DIG_W] = r[d*DIG_W +: DIG_W] + 4'd1;
          c = 1'b0;
        end
      end
    end
    return r;
  endfunction

  assign op  = ir_q[DW-1 -: DIG_W];
  assign adr = ir_q[AW-1:0];

  mbx_bcd_addsub #(.NDIG(DDIG)) u_alu (
    .a      (acc_q),
    .b      (opnd),
    .sub    (alu_sub),
    .sum    (alu_sum),
    .borrow (alu_borrow)
  );

  always_comb begin
    state_d  = state_q;
    pc_en    = 1'b0;
    pc_d     = bcd_inc(pc_q);
    ir_en    = 1'b0;
    acc_en   = 1'b0;
    acc_d    = alu_sum;
    neg_d    = 1'b0;
    out_en   = 1'b0;
    outv_d   = 1'b0;
    st_en    = 1'b0;
    in_ready = 1'b0;
    alu_sub  = (op == OPC_SUB);
    unique case (state_q)
      ST_FETCH: begin
        ir_en   = 1'b1;
        pc_en   = 1'b1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_FETCH;
        case (op)
          OPC_HLT: if (adr == '0) state_d = ST_HALT;
          OPC_ADD, OPC_SUB: begin
            acc_en = 1'b1;
            neg_d  = alu_borrow;
          end
          OPC_STA: st_en = 1'b1;
          OPC_LDA: begin
            acc_en = 1'b1;
            acc_d  = opnd;
          end
          OPC_BRA: begin
            pc_en = 1'b1;
            pc_d  = adr;
          end
          OPC_BRZ: if (acc_q == '0) begin
            pc_en = 1'b1;
            pc_d  = adr;
          end
          OPC_BRP: if (!neg_q) begin
            pc_en = 1'b1;
            pc_d  = adr;
          end
          OPC_IO: begin
            if (adr == AW'(1)) begin
              in_ready = 1'b1;
              if (in_valid) begin
                acc_en = 1'b1;
                acc_d  = in_data;
              end else begin
                state_d = ST_EXEC;
              end
            end else if (adr == AW'(2)) begin
              out_en = 1'b1;
              outv_d = 1'b1;
            end
          end
          default: ;
        endcase
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
      neg_q   <= 1'b0;
      outv_q  <= 1'b0;
      outd_q  <= '0;
      outn_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      outv_q  <= outv_d;
      if (pc_en)  pc_q  <= pc_d;
      if (ir_en)  ir_q  <= instr;
      if (acc_en) begin
        acc_q <= acc_d;
        neg_q <= neg_d;
      end
      if (out_en) begin
        outd_q <= acc_q;
        outn_q <= neg_q;
      end
    end
  end

  assign pc_o      = pc_q;
  assign opaddr_o  = adr;
  assign st_data   = acc_q;
  assign out_valid = outv_q;
  assign out_data  = outd_q;
  assign out_neg   = outn_q;
  assign halted    = (state_q == ST_HALT);

  // R8
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |=> !out_valid);

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    halted |=> (halted && !out_valid && !in_ready));

  // R7
  inp_wait_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_ready && !in_valid) |=> (in_ready && $stable(acc_q)));

  // R6
  brp_neg_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_EXEC && op == OPC_BRP && neg_q) |=> (pc_q == $past(pc_q)));

  // R3
  sub_flag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_EXEC && op == OPC_SUB && opnd > acc_q) |=> neg_q);

  // R5
  for (genvar d = 0; d < ADIG; d++) begin : g_pcchk
    pc_digit_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      pc_q[d*DIG_W +: DIG_W] <= 4'd9);
  end

endmodule

// File: rtl/mbx_cpu_top.sv
module mbx_cpu_top
  import mbx_pkg::*;
#(
  parameter int DDIG = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_en,
  input  logic [(DDIG-1)*DIG_W-1:0] ld_addr,
  input  logic [DDIG*DIG_W-1:0]     ld_data,
  input  logic                      in_valid,
  input  logic [DDIG*DIG_W-1:0]     in_data,
  output logic                      in_ready,
  output logic                      out_valid,
  output logic [DDIG*DIG_W-1:0]     out_data,
  output logic                      out_neg,
  output logic                      halted
);

  localparam int ADIG = DDIG - 1;
  localparam int AW   = ADIG * DIG_W;
  localparam int DW   = DDIG * DIG_W;

  logic          rs1_q, rs2_q;
  logic [AW-1:0] pc;
  logic [AW-1:0] opaddr;
  logic [DW-1:0] instr;
  logic [DW-1:0] opnd;
  logic          st_en;
  logic [DW-1:0] st_data;

  // assertion is immediate, release goes through two stages
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  mbx_mem #(.ADIG(ADIG), .DDIG(DDIG)) u_mem (
    .clk     (clk),
    .ld_en   (ld_en),
    .ld_addr (ld_addr),
    .ld_data (ld_data),
    .st_en   (st_en),
    .st_addr (opaddr),
    .st_data (st_data),
    .ra_addr (pc),
    .ra_data (instr),
    .rb_addr (opaddr),
    .rb_data (opnd)
  );

  mbx_ctrl #(.DDIG(DDIG)) u_ctrl (
    .clk       (clk),
    .rst_ni    (rs2_q),
    .instr     (instr),
    .opnd      (opnd),
    .pc_o      (pc),
    .opaddr_o  (opaddr),
    .st_en     (st_en),
    .st_data   (st_data),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_neg   (out_neg),
    .halted    (halted)
  );

endmodule

// File: tb/mbx_cpu_top_tb_top.sv
`timescale 1ns/1ps
module mbx_cpu_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic        ld_en;
  logic [7:0]  ld_addr;
  logic [11:0] ld_data;
  logic        in_valid;
  logic [11:0] in_data;
  logic        in_ready;
  logic        out_valid;
  logic [11:0] out_data;
  logic        out_neg;
  logic        halted;

  int n_cmp;
  int n_bad;
  string cur_req;

  mbx_cpu_top dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_neg(out_neg), .halted(halted)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int b2i(input logic [11:0] v);
    return int'(v[11:8]) * 100 + int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [11:0] i2b(input int x);
    return {4'(x / 100), 4'((x / 10) % 10), 4'(x % 10)};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural decimal model ----------------
  int m_mem[100];
  int m_pc, m_ir, m_acc, m_neg, m_st, m_sync, m_ov, m_od, m_on;

  task automatic m_clear();
    m_pc = 0; m_ir = 0; m_acc = 0; m_neg = 0; m_st = 0;
    m_ov = 0; m_od = 0; m_on = 0;
  endtask

  task automatic m_step();
    int op, ad, v;
    m_ov = 0;
    case (m_st)
      0: begin
        m_ir = m_mem[m_pc];
        m_pc = (m_pc + 1) % 100;
        m_st = 1;
      end
      1: begin
        op = m_ir / 100;
        ad = m_ir % 100;
        m_st = 0;
        case (op)
          0: if (ad == 0) m_st = 2;
          1: begin m_acc = (m_acc + m_mem[ad]) % 1000; m_neg = 0; end
          2: begin v = m_acc - m_mem[ad]; m_neg = (v < 0) ? 1 : 0; m_acc = (v + 1000) % 1000; end
          3: m_mem[ad] = m_acc;
          5: begin m_acc = m_mem[ad]; m_neg = 0; end
          6: m_pc = ad;
          7: if (m_acc == 0) m_pc = ad;
          8: if (m_neg == 0) m_pc = ad;
          9: begin
            if (ad == 1) begin
              if (in_valid) begin m_acc = b2i(in_data); m_neg = 0; end
              else m_st = 1;
            end else if (ad == 2) begin
              m_ov = 1; m_od = m_acc; m_on = m_neg;
            end
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sync = 0;
      m_clear();
    end else if (m_sync < 2) begin
      m_sync++;
      m_clear();
    end else begin
      m_step();
    end
    if (ld_en) m_mem[b2i({4'd0, ld_addr})] = b2i(ld_data);
  end

  // ---------------- per-cycle comparison and output capture ----------------
  logic [12:0] obs[$];

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "out_valid", int'(out_valid), m_ov);
      chk(cur_req, "out_data", b2i(out_data), m_od);
      chk(cur_req, "out_neg", int'(out_neg), m_on);
      chk(cur_req, "in_ready", int'(in_ready), (m_st == 1 && m_ir == 901) ? 1 : 0);
      chk(cur_req, "halted", int'(halted), (m_st == 2) ? 1 : 0);
      if (out_valid) obs.push_back({out_neg, out_data});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic begin_prog(input string req);
    @(negedge clk);
    #2 rst_n = 1'b0;
    cur_req = req;
    obs.delete();
    for (int a = 0; a < 100; a++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = i2b(a)[7:0]; ld_data = 12'h000;
    end
  endtask

  task automatic wr(input int a, input logic [11:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = i2b(a)[7:0]; ld_data = d;
  endtask

  task automatic release_rst();
    @(negedge clk);
    ld_en = 1'b0;
    // R1 outputs idle while reset is held
    chk("R1", "reset out_valid", int'(out_valid), 0);
    chk("R1", "reset in_ready", int'(in_ready), 0);
    chk("R1", "reset halted", int'(halted), 0);
    rst_n = 1'b1;
  endtask

  task automatic run_to_halt(input string req, input int maxc);
    int c;
    c = 0;
    while (!halted && c < maxc) begin
      @(negedge clk);
      c++;
    end
    chk(req, "halt reached", int'(halted), 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_outs(input string req, input logic [12:0] exp[$]);
    chk(req, "output count", obs.size(), exp.size());
    for (int i = 0; i < exp.size() && i < obs.size(); i++) begin
      chk(req, "output value", b2i(obs[i][11:0]), b2i(exp[i][11:0]));
      chk(req, "output flag", int'(obs[i][12]), int'(exp[i][12]));
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // ---------------- tests ----------------
  initial begin
    n_cmp = 0; n_bad = 0; cur_req = "R1";
    rst_n = 1'b0; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    in_valid = 1'b0; in_data = '0;

    // P1: R2 add, R3 subtract to negative, R6 branches not taken, R8 output
    begin_prog("R2 R3 R6 R8");
    wr(0, 12'h901); wr(1, 12'h110); wr(2, 12'h902); wr(3, 12'h211);
    wr(4, 12'h902); wr(5, 12'h812); wr(6, 12'h720); wr(7, 12'h902);
    wr(8, 12'h000); wr(10, 12'h456); wr(11, 12'h999); wr(12, 12'h000);
    in_valid = 1'b1; in_data = 12'h123;
    release_rst();
    run_to_halt("R9", 200);
    expect_outs("R3", '{13'h0579, 13'h1580, 13'h1580});
    in_valid = 1'b0;

    // P2: R4 load/store, R6 zero and positive branches, R2 wrap on add, R5 jump
    begin_prog("R4 R5 R6");
    wr(0, 12'h530); wr(1, 12'h231); wr(2, 12'h902); wr(3, 12'h330);
    wr(4, 12'h706); wr(5, 12'h600); wr(6, 12'h532); wr(7, 12'h133);
    wr(8, 12'h902); wr(9, 12'h899); wr(10, 12'h902); wr(11, 12'h000);
    wr(30, 12'h003); wr(31, 12'h001); wr(32, 12'h998); wr(33, 12'h003);
    wr(99, 12'h000);
    release_rst();
    run_to_halt("R6", 400);
    expect_outs("R6", '{13'h0002, 13'h0001, 13'h0000, 13'h0001});

    // P3: R5 counter wraps 99 to 00, executes self-written cell
    begin_prog("R5 R4");
    wr(0, 12'h698); wr(1, 12'h521); wr(2, 12'h902); wr(3, 12'h000);
    wr(42, 12'h321); wr(98, 12'h542); wr(99, 12'h300);
    release_rst();
    run_to_halt("R5", 200);
    expect_outs("R5", '{13'h0321});

    // P4: R11 load and store to cell 51 on the same edge
    begin_prog("R11");
    wr(0, 12'h550); wr(1, 12'h351); wr(2, 12'h551); wr(3, 12'h902);
    wr(4, 12'h000); wr(50, 12'h111);
    release_rst();
    repeat (5) @(negedge clk);
    ld_en = 1'b1; ld_addr = 8'h51; ld_data = 12'h222;
    @(negedge clk);
    ld_en = 1'b0;
    run_to_halt("R11", 200);
    expect_outs("R11", '{13'h0222});

    // P5: R7 input wait, R10 no-op codes, R9 halt is final
    begin_prog("R7 R10");
    wr(0, 12'h210); wr(1, 12'h901); wr(2, 12'h477); wr(3, 12'h903);
    wr(4, 12'h005); wr(5, 12'h902); wr(6, 12'h000); wr(10, 12'h001);
    in_valid = 1'b0;
    release_rst();
    begin
      int c;
      c = 0;
      while (!in_ready && c < 50) begin @(negedge clk); c++; end
    end
    repeat (5) begin
      @(negedge clk);
      chk("R7", "in_ready held while waiting", int'(in_ready), 1);
      chk("R7", "no output while waiting", int'(out_valid), 0);
    end
    in_valid = 1'b1; in_data = 12'h042;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7", "in_ready drops after accept", int'(in_ready), 0);
    run_to_halt("R9", 200);
    expect_outs("R10", '{13'h0042});
    cur_req = "R9";
    repeat (10) begin
      in_valid = ~in_valid;
      @(negedge clk);
      chk("R9", "halted stays", int'(halted), 1);
      chk("R9", "no strobe after halt", int'(out_valid), 0);
      chk("R9", "no input request after halt", int'(in_ready), 0);
    end
    in_valid = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule